// File: doc/BRIEF.md
# 8x8 Multiplier with Sign Correction

This block multiplies two 8-bit operands. A mode input selects plain unsigned arithmetic or two's-complement signed arithmetic. A single unsigned 8x8 array forms the raw 16-bit product in every mode. A signed result is never built by a separate signed array. It is reached by adjusting only the upper byte of that unsigned product, in at most two sequential steps:

- When operand B is negative, operand A is subtracted from the upper byte.
- When operand A is negative, operand B is subtracted from the upper byte.

Each subtraction wraps modulo 256, and any borrow is thrown away.

A caller presents both operands and the mode, then pulses `start` for one cycle. The block captures the operands and the mode on that edge. When the result is final, `done` goes high for one cycle, and the product then stays on the outputs until the next accepted start. The interface is a plain start/done control pair with no back-pressure:

- A start that arrives while a signed correction is still running is ignored.
- In the cycle after `done`, the block accepts a new start. In unsigned mode this allows one operation per cycle.

Top module: `mul_sign_fix`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) the outputs hold the unsigned product, `{prod_hi, prod_lo}` = op_a × op_b. `done` is high in the first cycle after the clock edge that accepted `start`.
- R2: In signed mode, when bit 7 of op_b is 1, op_a is subtracted modulo 256 from the high byte of the unsigned product.
- R3: In signed mode, when bit 7 of op_a is 1, op_b is subtracted modulo 256 from the high byte. With R2, the final 16-bit result equals the two's-complement product of the operands.
- R4: `prod_lo` always equals the low byte of the unsigned product op_a × op_b, in both modes. It does not change during the correction cycles.
- R5: The latency from the accepting edge to `done` is 1 + (number of operands with bit 7 set) cycles in signed mode. `done` is high only while the block is idle.
- R6: With no accepted start, `prod_hi`, `prod_lo` hold their value whatever the operand and mode inputs do, and `done` stays low.
- R7: A `start` during a signed correction is ignored. The running result is unaffected, and no extra `done` follows.
- R8: After reset, `prod_hi`, `prod_lo` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| prod_hi | output | 8 | Upper byte of the product |
| prod_lo | output | 8 | Lower byte of the product |
| done | output | 1 | One-cycle pulse when the product is final |

## Verification
Every unsigned operand pair is swept, which exercises each row and carry of the array. Signed mode uses seeded random pairs together with directed pairs chosen so that neither, only B, only A, or both sign bits are set. This separates the two correction paths, and also shows the correction count through the measured latency. Extreme values such as 0x80×0x80, 0xFF×0xFF and 0x7F×0x80 expose wrong borrow handling. A start issued mid-correction, and operand changes with no start, show whether the held result can be disturbed.

// File: rtl/mul_sign_fix_pkg.sv
package mul_sign_fix_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIX_B = 2'd1,
    ST_FIX_A = 2'd2
  } fix_state_t;
endpackage

// File: rtl/mul_pp_array.sv
module mul_pp_array #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mul_a,
  input  logic [W-1:0]   mul_b,
  output logic [2*W-1:0] mul_p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc [0:W];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] row;
    assign row        = {{W{1'b0}}, (mul_b[i] ? mul_a : {W{1'b0}})} << i;
    assign acc[i + 1] = acc[i] + row;
  end

  assign mul_p = acc[W];
endmodule

// File: rtl/mul_hi_sub.sv
module mul_hi_sub #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] hi_out
);
  logic [W:0] diff;

  always_comb begin
    diff   = {1'b0, hi_in} - {1'b0, subtrahend};
    hi_out = en ? diff[W-1:0] : hi_in;
  end
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
  import mul_sign_fix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       signed_mode,
  input  logic       a_neg,
  input  logic       b_neg,
  output logic       accept,
  output fix_state_t state,
  output logic       done
);
  fix_state_t state_nx;
  logic       pend_a, pend_a_nx;
  logic       done_nx;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    state_nx  = state;
    pend_a_nx = pend_a;
    done_nx   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (signed_mode && b_neg) begin
            state_nx  = ST_FIX_B;
            pend_a_nx = a_neg;
          end else if (signed_mode && a_neg) begin
            state_nx  = ST_FIX_A;
            pend_a_nx = 1'b0;
          end else begin
            done_nx   = 1'b1;
          end
        end
      end
      ST_FIX_B: begin
        if (pend_a) begin
          state_nx = ST_FIX_A;
        end else begin
          state_nx = ST_IDLE;
          done_nx  = 1'b1;
        end
        pend_a_nx = 1'b0;
      end
      ST_FIX_A: begin
        state_nx = ST_IDLE;
        done_nx  = 1'b1;
      end
      default: begin
        state_nx = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend_a <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= state_nx;
      pend_a <= pend_a_nx;
      done   <= done_nx;
    end
  end

  // R3
  fix_a_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX_A) |=> (state == ST_IDLE));

  // R5
  fix_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX_A) |=> done);
endmodule

// File: rtl/mul_sign_fix.sv
module mul_sign_fix
  import mul_sign_fix_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         done
);
  localparam int PW = 2 * W;

  fix_state_t    state;
  logic          accept;
  logic [W-1:0]  a_q, b_q;
  logic [PW-1:0] raw_p;
  logic [W-1:0]  sub_sel;
  logic [W-1:0]  hi_fixed;
  logic          fix_en;

  mul_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .a_neg       (op_a[W-1]),
    .b_neg       (op_b[W-1]),
    .accept      (accept),
    .state       (state),
    .done        (done)
  );

  mul_pp_array #(.W(W)) u_array (
    .mul_a (op_a),
    .mul_b (op_b),
    .mul_p (raw_p)
  );

  assign fix_en  = (state != ST_IDLE);
  assign sub_sel = (state == ST_FIX_B) ? a_q : b_q;

  mul_hi_sub #(.W(W)) u_sub (
    .en         (fix_en),
    .hi_in      (prod_hi),
    .subtrahend (sub_sel),
    .hi_out     (hi_fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      prod_hi <= '0;
      prod_lo <= '0;
    end else if (accept) begin
      a_q     <= op_a;
      b_q     <= op_b;
      prod_hi <= raw_p[PW-1:W];
      prod_lo <= raw_p[W-1:0];
    end else if (fix_en) begin
      prod_hi <= hi_fixed;
    end
  end

  // R1
  unsigned_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !signed_mode) |=> done);

  // R4
  lo_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(prod_lo));

  // R5
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> ($stable(prod_hi) && $stable(prod_lo) && !done));

  // R7
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/tb_mul_sign_fix.sv
module tb_mul_sign_fix;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       signed_mode = 1'b0;
  logic [7:0] op_a = 8'd0;
  logic [7:0] op_b = 8'd0;
  logic [7:0] prod_hi, prod_lo;
  logic       done;

  int total = 0;
  int bad   = 0;
  bit stop_run = 0;

  mul_sign_fix dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b, input logic s);
    logic signed [15:0] sp;
    logic [15:0]        up;
    sp = $signed(a) * $signed(b);
    up = a * b;
    return s ? sp : up;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic s);
    int lat, exp_lat;
    logic [15:0] exp_p;
    string tag;
    exp_p   = ref_prod(a, b, s);
    exp_lat = 1 + int'(s & b[7]) + int'(s & a[7]);
    if (!s) tag = "R1";
    else if (a[7]) tag = "R3";
    else if (b[7]) tag = "R2";
    else tag = "R3";
    op_a = a; op_b = b; signed_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check({prod_hi, prod_lo} == exp_p, tag, {prod_hi, prod_lo}, exp_p);
    check(prod_lo == 8'((a * b) & 8'hFF), "R4 low byte", prod_lo, 8'((a * b) & 8'hFF));
    check(lat == exp_lat, s ? "R5 latency" : "R1 latency", lat, exp_lat);
  endtask

  initial begin : watchdog
    #(8 * 195000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] hold_hi, hold_lo;
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(prod_hi == 0 && prod_lo == 0, "R8 product", {prod_hi, prod_lo}, 0);
    check(done == 0, "R8 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed signed corners
    run_op(8'h80, 8'h80, 1'b1);
    run_op(8'h7F, 8'h80, 1'b1);
    run_op(8'h80, 8'h7F, 1'b1);
    run_op(8'hFF, 8'hFF, 1'b1);
    run_op(8'hFF, 8'h01, 1'b1);
    run_op(8'h01, 8'hFF, 1'b1);
    run_op(8'h00, 8'h80, 1'b1);
    run_op(8'h7F, 8'h7F, 1'b1);
    run_op(8'hFF, 8'hFF, 1'b0);

    // R6: inputs wiggle, no start
    hold_hi = prod_hi; hold_lo = prod_lo;
    for (int k = 0; k < 4; k++) begin
      op_a = 8'(k * 37 + 3); op_b = 8'(k * 91 + 5); signed_mode = k[0];
      @(negedge clk);
      check(prod_hi == hold_hi && prod_lo == hold_lo, "R6 hold", {prod_hi, prod_lo}, {hold_hi, hold_lo});
      check(done == 0, "R6 no done", done, 0);
    end

    // R7: start during correction is ignored
    op_a = 8'h80; op_b = 8'h80; signed_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    op_a = 8'h03; op_b = 8'h05; signed_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 0, "R7 no early done", done, 0);
    @(negedge clk);
    check(done == 1, "R7 done at 3", done, 1);
    check({prod_hi, prod_lo} == 16'h4000, "R7 result", {prod_hi, prod_lo}, 16'h4000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(done == 0, "R7 no extra done", done, 0);
      check({prod_hi, prod_lo} == 16'h4000, "R7 result kept", {prod_hi, prod_lo}, 16'h4000);
    end

    // R1 exhaustive unsigned sweep
    for (int i = 0; i < 65536 && !stop_run; i++) begin
      run_op(8'(i), 8'(i >> 8), 1'b0);
    end

    // R2 R3 random signed pairs
    for (int i = 0; i < 25000; i++) begin
      run_op(8'($urandom), 8'($urandom), 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule